// File: doc/BRIEF.md
# Flash Control Register Bank

This block is the software-visible control bank that sits in front of a flash timing engine. A 16-bit peripheral bus reaches three registers: a mode register, a clock register and a status register. Each register is 16 bits wide. The high byte of every register is a guard byte. Reads always return a fixed signature in the guard byte. A write is accepted only when its guard byte carries a different, fixed key. A write with any other guard byte is refused. The refused write latches a sticky violation flag and sends a one-cycle reset request to the system.

The mode register drives the operation-select lines toward the engine: sector erase, full erase, erase-interrupt enable, emergency-exit-on-interrupt enable, program, and burst program. The clock register drives a clock-source select and a 6-bit divider. The status register has several kinds of bits:
- A lock bit that software reads and writes directly.
- An emergency-exit bit that software reads and writes directly.
- A protected-sector lock that changes state on each written 1.
- A failure flag that only software can clear.
- The violation flag.
- Live copies of the engine's busy and wait signals.

Setting the lock bit ends a burst program that is waiting for data. It does not disturb a single program or an erase that is already running.

Top module: `flash_ctl_regs`

## Requirements
- R1: A synchronous reset `rst` sets the outputs as follows: all mode outputs 0, clock select 1, divider 2, lock 1, protected-sector lock 1, emergency exit 0, `reset_req` 0, `bus_rdata` 0. The status low byte then reads 0x50.
- R2: One cycle after an address is presented, `bus_rdata` shows that register. Addresses 0 (mode), 1 (clock) and 2 (status) read with 0x96 in bits 15:8. Address 3 reads 0x0000, and writes to it have no effect and never raise a reset request.
- R3: A write to address 0, 1 or 2 with bits 15:8 equal to 0xA5 updates that register at the next edge. The mode register layout is: bit0 sector erase, bit1 full erase, bit2 erase-interrupt enable, bit3 emergency-exit enable, bit4 program, bit5 burst program. The clock register layout is: bits 7:6 clock select, bits 5:0 divider.
- R4: A write to address 0, 1 or 2 whose bits 15:8 are not 0xA5 sets the violation flag (status bit1). It drives `reset_req` high for exactly the next cycle and changes no other register bit.
- R5: The violation flag stays set until an accepted status write has bit1 = 0. An accepted status write with bit1 = 1 leaves the flag set.
- R6: An accepted status write with bit6 = 1 inverts the protected-sector lock (status bit6). A write with bit6 = 0 leaves it unchanged. Lock (bit4) and emergency exit (bit5) take the written value.
- R7: The failure flag (status bit7) sets after a cycle with `eng_clk_fail` high. It also sets after a cycle with `eng_abort` high while emergency-exit enable is 1. An accepted status write with bit7 = 0 clears the flag, and a set event in the same cycle takes precedence over the clear.
- R8: An accepted status write can move lock from 0 to 1. If it does so while burst program is 1 and `eng_wait` is 1, burst program clears at that edge and the other mode bits are kept.
- R9: Setting lock leaves program, sector erase and full erase unchanged. Burst program is also unchanged when `eng_wait` is 0.
- R10: Status bit0 reads `eng_busy` and bit3 reads `eng_wait`, both as sampled on the read edge. Bit2 reads 0. Writes to bits 0, 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data, guard byte in 15:8 |
| bus_rdata | output | 16 | Registered read data |
| eng_busy | input | 1 | Engine busy |
| eng_wait | input | 1 | Engine waiting for the next burst word |
| eng_clk_fail | input | 1 | Engine clock source failed |
| eng_abort | input | 1 | Operation aborted by an interrupt |
| ctl_erase_seg | output | 1 | Sector erase select |
| ctl_erase_all | output | 1 | Full erase select |
| ctl_int_en | output | 1 | Erase-interrupt enable |
| ctl_emerg_en | output | 1 | Emergency-exit-on-interrupt enable |
| ctl_wr | output | 1 | Program select |
| ctl_blk_wr | output | 1 | Burst program select |
| ctl_clk_sel | output | 2 | Clock source select |
| ctl_clk_div | output | 6 | Clock divider |
| ctl_lock | output | 1 | Array lock |
| ctl_seg_lock | output | 1 | Protected-sector lock |
| ctl_emex | output | 1 | Emergency exit |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- A refused write is followed by the reset request and the violation flag, and it leaves the clock register and mode register unchanged.
- The violation flag holds while no status write arrives.
- The protected-sector lock moves only on a written 1.
- A clock failure always sets the failure flag.
- A burst-ending lock write always drops burst program.
- Every readable register carries the signature byte.

The bench's scenarios are needed for the rest. These are the exact read-back encodings, the set-over-clear precedence of the failure flag, lock leaving a single program or an erase untouched, and the mirroring of busy and wait into the read path. The bench compares every output against its reference model on every clock.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam logic [7:0] KEY_WRITE = 8'hA5;
  localparam logic [7:0] KEY_READ  = 8'h96;

  localparam int ADR_MODE = 0;
  localparam int ADR_CLK  = 1;
  localparam int ADR_STAT = 2;
  localparam int NREG     = 3;

  localparam int ST_BUSY = 0;
  localparam int ST_KEYV = 1;
  localparam int ST_WAIT = 3;
  localparam int ST_LOCK = 4;
  localparam int ST_EMEX = 5;
  localparam int ST_SEG  = 6;
  localparam int ST_FAIL = 7;

  localparam int MODE_W = 6;

  typedef struct packed {
    logic blk_wr;
    logic wr;
    logic emerg_en;
    logic int_en;
    logic erase_all;
    logic erase_seg;
  } mode_t;
endpackage

// File: rtl/fc_key_gate.sv
module fc_key_gate #(
  parameter int ADDR_W = 2,
  parameter int KEY_W  = 8,
  parameter int NUM_R  = 3
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [KEY_W-1:0]  key_byte,
  output logic [NUM_R-1:0]  good_wr,
  output logic              key_bad
);
  import flash_ctl_pkg::*;

  logic key_ok;
  logic hit;

  assign key_ok  = (key_byte == KEY_W'(KEY_WRITE));
  assign hit     = bus_we && (int'(bus_addr) < NUM_R);
  assign key_bad = hit && !key_ok;

  for (genvar i = 0; i < NUM_R; i++) begin : g_strobe
    assign good_wr[i] = bus_we && key_ok && (int'(bus_addr) == i);
  end
endmodule

// File: rtl/fc_cfg_bank.sv
module fc_cfg_bank #(
  parameter int LOW_W   = 8,
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 6,
  parameter int SEL_RST = 1,
  parameter int DIV_RST = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_wr,
  input  logic                     clk_wr,
  input  logic [LOW_W-1:0]         wlow,
  input  logic                     blk_abort,
  output flash_ctl_pkg::mode_t     mode,
  output logic [SEL_W-1:0]         clk_sel,
  output logic [DIV_W-1:0]         clk_div
);
  import flash_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      clk_sel <= SEL_W'(SEL_RST);
      clk_div <= DIV_W'(DIV_RST);
    end else begin
      if (mode_wr)
        mode <= mode_t'(wlow[MODE_W-1:0]);
      else if (blk_abort)
        mode.blk_wr <= 1'b0;
      if (clk_wr) begin
        clk_sel <= wlow[DIV_W +: SEL_W];
        clk_div <= wlow[DIV_W-1:0];
      end
    end
  end

  // R8
  blk_end_chk: assert property (@(posedge clk) disable iff (rst)
    blk_abort && !mode_wr |=> !mode.blk_wr);
endmodule

// File: rtl/fc_status_bank.sv
module fc_status_bank (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic w_lock,
  input  logic w_emex,
  input  logic w_seg,
  input  logic w_keyv,
  input  logic w_fail,
  input  logic key_bad,
  input  logic clk_fail,
  input  logic abort,
  input  logic emerg_en,
  input  logic blk_wr,
  input  logic eng_wait,
  output logic lock,
  output logic emex,
  output logic seg_lock,
  output logic fail,
  output logic key_viol,
  output logic blk_abort
);
  logic fail_evt;

  assign fail_evt  = clk_fail || (abort && emerg_en);
  assign blk_abort = wr_en && w_lock && !lock && blk_wr && eng_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock     <= 1'b1;
      emex     <= 1'b0;
      seg_lock <= 1'b1;
      fail     <= 1'b0;
      key_viol <= 1'b0;
    end else begin
      if (wr_en) begin
        lock <= w_lock;
        emex <= w_emex;
        if (w_seg)  seg_lock <= !seg_lock;
        if (!w_keyv) key_viol <= 1'b0;
      end
      if (key_bad) key_viol <= 1'b1;
      if (fail_evt)
        fail <= 1'b1;
      else if (wr_en && !w_fail)
        fail <= 1'b0;
    end
  end

  // R5
  keyv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    key_viol && !wr_en |=> key_viol);
  // R6
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && w_seg) |=> $stable(seg_lock));
  // R7
  fail_set_chk: assert property (@(posedge clk) disable iff (rst)
    clk_fail |=> fail);
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16,
  parameter int KEY_W   = 8,
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 6,
  parameter int SEL_RST = 1,
  parameter int DIV_RST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_wait,
  input  logic              eng_clk_fail,
  input  logic              eng_abort,
  output logic              ctl_erase_seg,
  output logic              ctl_erase_all,
  output logic              ctl_int_en,
  output logic              ctl_emerg_en,
  output logic              ctl_wr,
  output logic              ctl_blk_wr,
  output logic [SEL_W-1:0]  ctl_clk_sel,
  output logic [DIV_W-1:0]  ctl_clk_div,
  output logic              ctl_lock,
  output logic              ctl_seg_lock,
  output logic              ctl_emex,
  output logic              reset_req
);
  import flash_ctl_pkg::*;

  localparam int LOW_W = DATA_W - KEY_W;

  logic [NREG-1:0]  good_wr;
  logic             key_bad;
  logic [LOW_W-1:0] wlow;
  mode_t            mode;
  logic             fail, key_viol, blk_abort;
  logic [LOW_W-1:0] rd_low;

  assign wlow = bus_wdata[LOW_W-1:0];

  fc_key_gate #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .NUM_R(NREG)) u_gate (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .key_byte (bus_wdata[DATA_W-1:LOW_W]),
    .good_wr  (good_wr),
    .key_bad  (key_bad)
  );

  fc_cfg_bank #(.LOW_W(LOW_W), .SEL_W(SEL_W), .DIV_W(DIV_W),
                .SEL_RST(SEL_RST), .DIV_RST(DIV_RST)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (good_wr[ADR_MODE]),
    .clk_wr    (good_wr[ADR_CLK]),
    .wlow      (wlow),
    .blk_abort (blk_abort),
    .mode      (mode),
    .clk_sel   (ctl_clk_sel),
    .clk_div   (ctl_clk_div)
  );

  fc_status_bank u_stat (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (good_wr[ADR_STAT]),
    .w_lock    (wlow[ST_LOCK]),
    .w_emex    (wlow[ST_EMEX]),
    .w_seg     (wlow[ST_SEG]),
    .w_keyv    (wlow[ST_KEYV]),
    .w_fail    (wlow[ST_FAIL]),
    .key_bad   (key_bad),
    .clk_fail  (eng_clk_fail),
    .abort     (eng_abort),
    .emerg_en  (mode.emerg_en),
    .blk_wr    (mode.blk_wr),
    .eng_wait  (eng_wait),
    .lock      (ctl_lock),
    .emex      (ctl_emex),
    .seg_lock  (ctl_seg_lock),
    .fail      (fail),
    .key_viol  (key_viol),
    .blk_abort (blk_abort)
  );

  assign ctl_erase_seg = mode.erase_seg;
  assign ctl_erase_all = mode.erase_all;
  assign ctl_int_en    = mode.int_en;
  assign ctl_emerg_en  = mode.emerg_en;
  assign ctl_wr        = mode.wr;
  assign ctl_blk_wr    = mode.blk_wr;

  always_comb begin
    rd_low = '0;
    case (int'(bus_addr))
      ADR_MODE: rd_low[MODE_W-1:0] = mode;
      ADR_CLK:  rd_low[SEL_W+DIV_W-1:0] = {ctl_clk_sel, ctl_clk_div};
      ADR_STAT: begin
        rd_low[ST_BUSY] = eng_busy;
        rd_low[ST_KEYV] = key_viol;
        rd_low[ST_WAIT] = eng_wait;
        rd_low[ST_LOCK] = ctl_lock;
        rd_low[ST_EMEX] = ctl_emex;
        rd_low[ST_SEG]  = ctl_seg_lock;
        rd_low[ST_FAIL] = fail;
      end
      default: rd_low = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      reset_req <= 1'b0;
    end else begin
      bus_rdata <= (int'(bus_addr) < NREG) ? {KEY_W'(KEY_READ), rd_low} : '0;
      reset_req <= key_bad;
    end
  end

  // R4
  reset_req_chk: assert property (@(posedge clk) disable iff (rst)
    key_bad |=> reset_req && key_viol);
  // R4
  bad_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    key_bad |=> $stable(ctl_clk_sel) && $stable(ctl_clk_div) && $stable(mode));
  // R2
  sig_byte_chk: assert property (@(posedge clk) disable iff (rst)
    int'(bus_addr) < NREG |=> bus_rdata[DATA_W-1:LOW_W] == KEY_W'(KEY_READ));
endmodule

// File: tb/sim_flash_ctl_regs.sv
module sim_flash_ctl_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic eng_busy = 0, eng_wait = 0, eng_clk_fail = 0, eng_abort = 0;
  logic ctl_erase_seg, ctl_erase_all, ctl_int_en, ctl_emerg_en, ctl_wr, ctl_blk_wr;
  logic [1:0] ctl_clk_sel;
  logic [5:0] ctl_clk_div;
  logic ctl_lock, ctl_seg_lock, ctl_emex, reset_req;

  always #2 clk = ~clk;

  flash_ctl_regs u0 (.*);

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference model state
  logic [5:0]  m_mode;
  logic [1:0]  m_sel;
  logic [5:0]  m_div;
  logic        m_lock, m_emex, m_seg, m_fail, m_kv, m_rr, m_live;
  logic [15:0] m_rdata;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] low;
    logic good, bad, fevt;
    cycles++;
    if (rst) begin
      m_mode = 0; m_sel = 1; m_div = 2; m_lock = 1; m_emex = 0; m_seg = 1;
      m_fail = 0; m_kv = 0; m_rr = 0; m_rdata = 0; m_live = 0;
    end else begin
      m_live = 1;
      case (bus_addr)
        2'd0: low = {2'b00, m_mode};
        2'd1: low = {m_sel, m_div};
        2'd2: low = {m_fail, m_seg, m_emex, m_lock, eng_wait, 1'b0, m_kv, eng_busy};
        default: low = 0;
      endcase
      m_rdata = (bus_addr == 2'd3) ? 16'h0000 : {8'h96, low};
      good = bus_we && bus_addr != 2'd3 && bus_wdata[15:8] == 8'hA5;
      bad  = bus_we && bus_addr != 2'd3 && bus_wdata[15:8] != 8'hA5;
      fevt = eng_clk_fail || (eng_abort && m_mode[3]);
      m_rr = bad;
      if (bad) m_kv = 1;
      if (good && bus_addr == 2'd0) m_mode = bus_wdata[5:0];
      if (good && bus_addr == 2'd1) begin m_sel = bus_wdata[7:6]; m_div = bus_wdata[5:0]; end
      if (good && bus_addr == 2'd2) begin
        if (bus_wdata[4] && !m_lock && m_mode[5] && eng_wait) m_mode[5] = 0;
        m_lock = bus_wdata[4];
        m_emex = bus_wdata[5];
        if (bus_wdata[6]) m_seg = !m_seg;
        if (!bus_wdata[1]) m_kv = 0;
        if (!bus_wdata[7]) m_fail = 0;
      end
      if (fevt) m_fail = 1;
    end
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      chk(bus_rdata == m_rdata, "R2 rdata", bus_rdata, m_rdata);
      chk({ctl_blk_wr, ctl_wr, ctl_emerg_en, ctl_int_en, ctl_erase_all, ctl_erase_seg} == m_mode,
          "R3 mode", 16'({ctl_blk_wr, ctl_wr, ctl_emerg_en, ctl_int_en, ctl_erase_all, ctl_erase_seg}), 16'(m_mode));
      chk({ctl_clk_sel, ctl_clk_div} == {m_sel, m_div}, "R3 clk", 16'({ctl_clk_sel, ctl_clk_div}), 16'({m_sel, m_div}));
      chk(reset_req == m_rr, "R4 reset_req", 16'(reset_req), 16'(m_rr));
      chk({ctl_lock, ctl_seg_lock, ctl_emex} == {m_lock, m_seg, m_emex}, "R6 status outs",
          16'({ctl_lock, ctl_seg_lock, ctl_emex}), 16'({m_lock, m_seg, m_emex}));
    end
  end

  task automatic put(input logic we, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    put(1, a, d);
    put(0, a, 16'h0);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    put(0, a, 16'h0);
    @(negedge clk);
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ctl_clk_sel == 2'd1 && ctl_clk_div == 6'd2, "R1 clk reset", 16'({ctl_clk_sel, ctl_clk_div}), 16'h0042);
    chk(ctl_lock && ctl_seg_lock && !ctl_emex && !reset_req && !ctl_blk_wr && !ctl_wr,
        "R1 flags reset", 16'({ctl_lock, ctl_seg_lock, ctl_emex, reset_req}), 16'b1100);
    rd_chk(2'd2, 16'h9650, "R1 status reset");
    // R3 accepted writes
    wr(2'd0, 16'hA521);
    rd_chk(2'd0, 16'h9621, "R3 mode write");
    chk(ctl_blk_wr && ctl_erase_seg && !ctl_wr, "R3 mode outs", 16'({ctl_blk_wr, ctl_erase_seg, ctl_wr}), 16'b110);
    wr(2'd1, 16'hA5C7);
    rd_chk(2'd1, 16'h96C7, "R3 clk write");
    // R4 wrong key
    put(1, 2'd1, 16'h1234);
    put(0, 2'd1, 16'h0);
    chk(reset_req == 1'b1, "R4 reset pulse", 16'(reset_req), 16'h1);
    @(negedge clk);
    chk(reset_req == 1'b0, "R4 pulse width", 16'(reset_req), 16'h0);
    rd_chk(2'd1, 16'h96C7, "R4 clk kept");
    rd_chk(2'd2, 16'h9652, "R4 key viol set");
    // R5 sticky
    wr(2'd2, 16'hA512);
    rd_chk(2'd2, 16'h9652, "R5 kept with bit1=1");
    wr(2'd2, 16'hA510);
    rd_chk(2'd2, 16'h9650, "R5 cleared");
    // R6 toggle
    wr(2'd2, 16'hA550);
    rd_chk(2'd2, 16'h9610, "R6 toggle");
    wr(2'd2, 16'hA510);
    rd_chk(2'd2, 16'h9610, "R6 zero no effect");
    wr(2'd2, 16'hA550);
    rd_chk(2'd2, 16'h9650, "R6 toggle back");
    // R10 mirrors
    eng_busy = 1; eng_wait = 1;
    rd_chk(2'd2, 16'h9659, "R10 busy wait mirror");
    eng_busy = 0; eng_wait = 0;
    wr(2'd2, 16'hA51D);
    rd_chk(2'd2, 16'h9650, "R10 writes ignored");
    // R7 fail
    @(negedge clk); eng_clk_fail = 1;
    @(negedge clk); eng_clk_fail = 0;
    rd_chk(2'd2, 16'h96D0, "R7 clk fail");
    wr(2'd2, 16'hA590);
    rd_chk(2'd2, 16'h96D0, "R7 bit7=1 keeps");
    wr(2'd2, 16'hA510);
    rd_chk(2'd2, 16'h9650, "R7 cleared");
    put(1, 2'd2, 16'hA510); eng_clk_fail = 1;
    put(0, 2'd2, 16'h0); eng_clk_fail = 0;
    rd_chk(2'd2, 16'h96D0, "R7 set beats clear");
    wr(2'd2, 16'hA510);
    wr(2'd0, 16'hA500);
    @(negedge clk); eng_abort = 1;
    @(negedge clk); eng_abort = 0;
    rd_chk(2'd2, 16'h9650, "R7 abort without enable");
    wr(2'd0, 16'hA508);
    @(negedge clk); eng_abort = 1;
    @(negedge clk); eng_abort = 0;
    rd_chk(2'd2, 16'h96D0, "R7 abort with enable");
    // R8 / R9 lock during burst
    wr(2'd2, 16'hA500);
    rd_chk(2'd2, 16'h9640, "R8 unlocked");
    wr(2'd0, 16'hA530);
    eng_wait = 1;
    wr(2'd2, 16'hA510);
    chk(!ctl_blk_wr, "R8 burst ended", 16'(ctl_blk_wr), 16'h0);
    chk(ctl_wr, "R9 program kept", 16'(ctl_wr), 16'h1);
    eng_wait = 0;
    wr(2'd2, 16'hA500);
    wr(2'd0, 16'hA523);
    wr(2'd2, 16'hA510);
    rd_chk(2'd0, 16'h9623, "R9 lock leaves erase and burst");
    // R2 unused address
    put(1, 2'd3, 16'h1234);
    put(0, 2'd3, 16'h0);
    chk(!reset_req, "R2 addr3 no reset", 16'(reset_req), 16'h0);
    rd_chk(2'd3, 16'h0000, "R2 addr3 reads zero");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule